// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller with Poll Readout

This block gathers eight edge-triggered interrupt inputs and ranks them by fixed priority, with level 0 highest. A host reaches it through a byte-wide port with one address bit. Address 0 takes the word that starts setup and, once setup is done, the command words. Address 1 takes the rest of the setup words, and after that it holds the mask. The block keeps three 8-bit registers: pending requests, in-service levels and the mask. It raises `int_out` whenever an unmasked request outranks every level now in service.

A host without an acknowledge cycle services the block by polling. It writes a poll command, then reads address 0. That read returns a flag for "something pending" and the winning level, and it also moves that level into service. End-of-service commands then clear in-service bits. The setup words that describe the vector base and the cascade wiring are held and brought out on ports for neighbouring logic. This block does no multi-chip vectoring with them.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `int_out` is 0 and reads of both addresses return 0x00. Until setup completes, `int_out` stays 0 and address-1 writes do not change the mask.
- R2: An address-0 write with bit 4 = 1 starts setup. It clears the mask, the pending and in-service registers, the read select (back to pending), any armed poll, `vec_base`, `cas_cfg` and auto-clear mode. It takes bit 1 (1 = single, no cascade word) and bit 0 (1 = fourth word follows). The address-1 writes that follow are taken in order: the second word, whose bits 7:3 go to `vec_base`; then the cascade word into `cas_cfg`, only when bit 1 was 0; then the fourth word, only when bit 0 was 1. None of these writes touches the mask.
- R3: Once setup is complete, an address-1 write loads the mask and an address-1 read returns it.
- R4: A 0-to-1 transition on `irq_in[k]` sets pending bit k one cycle later. A level that stays high does not set the bit again after it is cleared. Masked requests are still recorded.
- R5: `int_out` is 1 exactly when setup is complete and some pending, unmasked level k has no in-service bit at k or at any level numbered below k.
- R6: An address-0 write with bits 4:3 = 01 is a read-select/poll command. If its bit 1 = 1, bit 0 selects what address-0 reads return: 0 gives pending, 1 gives in-service (so 0x0A and 0x0B). If bit 1 = 0, the selection is left as it was.
- R7: A read-select/poll command with bit 2 = 1 (for example 0x0E) arms a poll. The next address-0 read returns bit 7 = 1 and bits 2:0 = the winning level under R5's rule, or 0x00 if there is no winner.
- R8: A poll read with a winner clears that pending bit and sets that in-service bit. The poll disarms after the one read, and later address-0 reads follow the read select again.
- R9: An address-0 write with bits 4:3 = 00 is an end-of-service command. Bits 7:5 = 001 (0x20) clears the lowest-numbered set in-service bit. Bits 7:5 = 011 (0x60 to 0x67) clears in-service bit n = bits 2:0. Any other code leaves the in-service register unchanged.
- R10: When the fourth setup word has bit 1 = 1, poll reads still report the winner and clear its pending bit, but do not set any in-service bit.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt inputs, synchronous to clk, rising edge recorded |
| addr | input | 1 | Host port address (0 or 1) |
| wr_en | input | 1 | Host write strobe, one cycle per word |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid in the cycle rd_en is high, 0 otherwise |
| int_out | output | 1 | Interrupt request to the host |
| vec_base | output | 5 | Bits 7:3 of the stored second setup word |
| cas_cfg | output | 8 | Stored cascade setup word |

## Verification
Directed sequences set the controller up in each setup form: cascade with a fourth word, single without one, and single with auto-clear. This tells apart how many address-1 writes setup consumes before the mask takes writes. Staggered rising edges on several inputs, with levels both above and below what is in service, separate a priority ranking that nests from one that only picks the lowest pending bit. A long random mix of edge toggles, mask writes, polls, both kinds of end-of-service command (plus codes that must do nothing) and register-select reads is checked against a bench model. That mix exposes wrong bit choice in clearing, a poll that does not disarm, and masked requests that leak into `int_out` or the poll result.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int N_LVL = 8;
  localparam int LVL_W = $clog2(N_LVL);
  localparam int DW    = 8;
  localparam int VB_W  = DW - LVL_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WORD2, ST_WORD3, ST_WORD4, ST_RUN
  } setup_st_e;

  typedef struct packed {
    logic [VB_W-1:0] vec_base;
    logic [DW-1:0]   cas;
    logic            auto_clr;
  } pic_cfg_t;

  // {valid, level} of the lowest-numbered set bit
  function automatic logic [LVL_W:0] lowest_set(input logic [N_LVL-1:0] v);
    logic [LVL_W:0] r;
    r = '0;
    for (int i = N_LVL - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, LVL_W'(i)};
    end
    return r;
  endfunction

  // levels allowed to interrupt given the top in-service level
  function automatic logic [N_LVL-1:0] allow_below(input logic [LVL_W:0] top);
    logic [N_LVL-1:0] one;
    one = N_LVL'(1);
    return top[LVL_W] ? ((one << top[LVL_W-1:0]) - one) : '1;
  endfunction

  function automatic logic [LVL_W:0] pick_winner(input logic [N_LVL-1:0] req,
                                                 input logic [N_LVL-1:0] msk,
                                                 input logic [N_LVL-1:0] svc);
    return lowest_set(req & ~msk & allow_below(lowest_set(svc)));
  endfunction

  function automatic logic [N_LVL-1:0] lvl_onehot(input logic [LVL_W-1:0] l);
    return N_LVL'(1) << l;
  endfunction
endpackage

// File: rtl/pic_setup_seq.sv
module pic_setup_seq
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr0,
  input  logic          wr1,
  input  logic [DW-1:0] wdata,
  output logic          setup_start,
  output logic          running,
  output pic_cfg_t      cfg
);
  setup_st_e st_q;
  logic      single_q, want4_q;

  assign setup_start = wr0 && wdata[4];
  assign running     = (st_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      single_q <= 1'b0;
      want4_q  <= 1'b0;
      cfg      <= '0;
    end else if (setup_start) begin
      st_q     <= ST_WORD2;
      single_q <= wdata[1];
      want4_q  <= wdata[0];
      cfg      <= '0;
    end else if (wr1) begin
      case (st_q)
        ST_WORD2: begin
          cfg.vec_base <= wdata[DW-1:LVL_W];
          st_q <= !single_q ? ST_WORD3 : (want4_q ? ST_WORD4 : ST_RUN);
        end
        ST_WORD3: begin
          cfg.cas <= wdata;
          st_q    <= want4_q ? ST_WORD4 : ST_RUN;
        end
        ST_WORD4: begin
          cfg.auto_clr <= wdata[1];
          st_q         <= ST_RUN;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  AST_CASCADE_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WORD3) |-> !single_q);  // R2
  AST_SETUP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    setup_start |=> !running);  // R2
endmodule

// File: rtl/pic_req_reg.sv
module pic_req_reg
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] irq_in,
  input  logic [N_LVL-1:0] take_vec,
  input  logic             setup_start,
  output logic [N_LVL-1:0] req_q
);
  logic [N_LVL-1:0] prev_q;
  logic [N_LVL-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= irq_in;
      req_q  <= setup_start ? '0 : ((req_q & ~take_vec) | rise);
    end
  end

  AST_EDGE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_start && (|rise)) |=> ((req_q & $past(rise)) == $past(rise)));  // R4
endmodule

// File: rtl/pic_svc_reg.sv
module pic_svc_reg
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_start,
  input  logic [N_LVL-1:0] set_vec,
  input  logic             end_lowest,
  input  logic             end_named,
  input  logic [LVL_W-1:0] end_lvl,
  output logic [N_LVL-1:0] svc_q
);
  logic [LVL_W:0]   top;
  logic [N_LVL-1:0] clr_vec;

  assign top = lowest_set(svc_q);

  always_comb begin
    clr_vec = '0;
    if (end_lowest && top[LVL_W]) clr_vec = lvl_onehot(top[LVL_W-1:0]);
    if (end_named)                clr_vec = lvl_onehot(end_lvl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           svc_q <= '0;
    else if (setup_start) svc_q <= '0;
    else                  svc_q <= (svc_q & ~clr_vec) | set_vec;
  end

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_vec) && !setup_start) |=> ((svc_q & $past(clr_vec) & ~$past(set_vec)) == '0));  // R9
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LVL-1:0]     irq_in,
  input  logic                 addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 int_out,
  output logic [VB_W-1:0]      vec_base,
  output logic [DW-1:0]        cas_cfg
);
  logic wr0, wr1, rd0;
  logic setup_start, running;
  pic_cfg_t cfg;
  logic cmd_end, cmd_sel, end_lowest, end_named;
  logic [N_LVL-1:0] mask_q, req_q, svc_q, take_vec, set_vec;
  logic sel_svc_q, poll_q;
  logic [LVL_W:0] winner;
  logic win_v, poll_take;

  assign wr0 = wr_en && !addr;
  assign wr1 = wr_en &&  addr;
  assign rd0 = rd_en && !addr;

  pic_setup_seq u_setup (
    .clk(clk), .rst_n(rst_n), .wr0(wr0), .wr1(wr1), .wdata(wdata),
    .setup_start(setup_start), .running(running), .cfg(cfg)
  );

  assign cmd_end    = running && wr0 && !wdata[4] && !wdata[3];
  assign cmd_sel    = running && wr0 && !wdata[4] &&  wdata[3];
  assign end_lowest = cmd_end && (wdata[7:5] == 3'b001);
  assign end_named  = cmd_end && (wdata[7:5] == 3'b011);

  assign winner    = pick_winner(req_q, mask_q, svc_q);
  assign win_v     = running && winner[LVL_W];
  assign poll_take = rd0 && poll_q && win_v;
  assign take_vec  = poll_take ? lvl_onehot(winner[LVL_W-1:0]) : '0;
  assign set_vec   = cfg.auto_clr ? '0 : take_vec;

  pic_req_reg u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .take_vec(take_vec),
    .setup_start(setup_start), .req_q(req_q)
  );

  pic_svc_reg u_svc (
    .clk(clk), .rst_n(rst_n), .setup_start(setup_start), .set_vec(set_vec),
    .end_lowest(end_lowest), .end_named(end_named), .end_lvl(wdata[LVL_W-1:0]),
    .svc_q(svc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || setup_start) begin
      mask_q    <= '0;
      sel_svc_q <= 1'b0;
      poll_q    <= 1'b0;
    end else begin
      if (wr1 && running) mask_q <= wdata;
      if (cmd_sel && wdata[1]) sel_svc_q <= wdata[0];
      if (cmd_sel)  poll_q <= wdata[2];
      else if (rd0) poll_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr)        rdata = mask_q;
      else if (poll_q) rdata = {win_v, {(DW-LVL_W-1){1'b0}}, winner[LVL_W-1:0] & {LVL_W{win_v}}};
      else             rdata = sel_svc_q ? svc_q : req_q;
    end
  end

  assign int_out  = win_v;
  assign vec_base = cfg.vec_base;
  assign cas_cfg  = cfg.cas;

  AST_POLL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && poll_q && !wr_en) |=> !poll_q);  // R8
  AST_POLL_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !cfg.auto_clr) |=> svc_q[$past(winner[LVL_W-1:0])]);  // R8
  AST_POLL_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && poll_q && !int_out) |-> (rdata == '0));  // R7
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr1 && !setup_start) |=> $stable(mask_q));  // R3
endmodule

// File: tb/tb_pic_ctrl.sv
module tb_pic_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic int_out;
  logic [4:0] vec_base;
  logic [7:0] cas_cfg;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_irr = '0, m_isr = '0, m_mask = '0, m_prev = '0, m_cas = '0;
  logic [4:0] m_vb = '0;
  logic m_sel = 0, m_poll = 0, m_single = 0, m_want4 = 0, m_aclr = 0;
  int   m_phase = 0;
  logic [7:0] cur_irq = '0;

  always #10 clk = ~clk;

  pic_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .int_out(int_out),
    .vec_base(vec_base), .cas_cfg(cas_cfg)
  );

  // scan from level 0 upward; stop at the first level in service
  function automatic logic [3:0] m_pend();
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) return 4'd0;
      if (m_irr[i] && !m_mask[i]) return {1'b1, 3'(i)};
    end
    return 4'd0;
  endfunction

  function automatic logic m_int();
    logic [3:0] p;
    p = m_pend();
    return (m_phase == 4) && p[3];
  endfunction

  function automatic logic [7:0] m_read(input logic a);
    logic [3:0] p;
    p = m_pend();
    if (a) return m_mask;
    if (m_poll) return (m_phase == 4 && p[3]) ? {1'b1, 4'b0, p[2:0]} : 8'h00;
    return m_sel ? m_isr : m_irr;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(input logic [7:0] irq, input logic w, input logic r,
                              input logic a, input logic [7:0] d);
    logic [7:0] rise, clr;
    logic [3:0] p;
    rise = irq & ~m_prev;
    m_prev = irq;
    clr = '0;
    if (w && !a && d[4]) begin
      m_phase = 1; m_single = d[1]; m_want4 = d[0];
      m_mask = 0; m_isr = 0; m_irr = 0; m_sel = 0; m_poll = 0;
      m_vb = 0; m_cas = 0; m_aclr = 0;
      return;
    end
    if (w && a) begin
      case (m_phase)
        1: begin m_vb = d[7:3]; m_phase = !m_single ? 2 : (m_want4 ? 3 : 4); end
        2: begin m_cas = d; m_phase = m_want4 ? 3 : 4; end
        3: begin m_aclr = d[1]; m_phase = 4; end
        4: m_mask = d;
        default: ;
      endcase
    end
    if (w && !a && m_phase == 4) begin
      if (!d[3]) begin
        if (d[7:5] == 3'b001) begin
          for (int i = 0; i < 8; i++) if (m_isr[i]) begin m_isr[i] = 1'b0; break; end
        end else if (d[7:5] == 3'b011) m_isr[d[2:0]] = 1'b0;
      end else begin
        if (d[1]) m_sel = d[0];
        m_poll = d[2];
      end
    end
    if (r && !a && m_poll) begin
      p = m_pend();
      if (m_phase == 4 && p[3]) begin
        clr[p[2:0]] = 1'b1;
        if (!m_aclr) m_isr[p[2:0]] = 1'b1;
      end
      m_poll = 0;
    end
    m_irr = (m_irr & ~clr) | rise;
  endtask

  task automatic step(input logic [7:0] irq, input logic w, input logic r,
                      input logic a, input logic [7:0] d);
    logic [7:0] exp;
    string tag;
    @(negedge clk);
    irq_in = irq; wr_en = w; rd_en = r; addr = a; wdata = d;
    exp = m_read(a);
    tag = a ? "R3" : (m_poll ? "R7" : "R6");
    #2;
    if (r) check(rdata, exp, tag);
    @(posedge clk);
    model_update(irq, w, r, a, d);
    #1;
    check({7'b0, int_out}, {7'b0, m_int()}, "R5");
    check({3'b0, vec_base}, {3'b0, m_vb}, "R2");
    check(cas_cfg, m_cas, "R2");
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d); step(cur_irq, 1, 0, a, d); endtask
  task automatic rd(input logic a);                      step(cur_irq, 0, 1, a, 8'h00); endtask
  task automatic set_irq(input logic [7:0] v); cur_irq = v; step(v, 0, 0, 0, 8'h00); endtask
  task automatic idle(); step(cur_irq, 0, 0, 0, 8'h00); endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset state, mask ignores writes before setup
    rd(1); rd(0);
    check({7'b0, int_out}, 8'h00, "R1");
    wr(1, 8'hFF); rd(1);
    set_irq(8'h04); rd(0);
    check({7'b0, int_out}, 8'h00, "R1");

    // R2: cascade form with fourth word; mask untouched by setup words
    wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h04); rd(1); wr(1, 8'h01);
    check({3'b0, vec_base}, 8'h01, "R2");
    check(cas_cfg, 8'h04, "R2");
    // R3: mask load and read
    wr(1, 8'hA5); rd(1); wr(1, 8'h00); rd(1);

    // R4/R5/R6/R7/R8 directed
    set_irq(8'h00); set_irq(8'h08); wr(0, 8'h0A); rd(0);
    wr(0, 8'h0E); rd(0); rd(0);                 // R7 then R8 disarm
    wr(0, 8'h0B); rd(0);                        // R8 in-service level 3
    set_irq(8'h28); wr(0, 8'h08); rd(0);        // R5 level 5 blocked, select kept (R6)
    set_irq(8'h2A); idle();                     // level 1 outranks
    wr(0, 8'h0C); rd(0);                        // poll grants level 1
    wr(0, 8'h40); rd(0);                        // R9 no-op code
    wr(0, 8'h20); rd(0);                        // R9 lowest clears level 1
    wr(0, 8'h63); rd(0);                        // R9 named level 3
    wr(1, 8'h20); wr(0, 8'h0E); rd(0);          // masked level 5 hidden (R4)
    wr(0, 8'h0A); rd(0);
    set_irq(8'h00); set_irq(8'h01); wr(1, 8'h00); wr(0, 8'h0E); rd(0);
    wr(0, 8'h0E); rd(0);                        // R7 pending 5 only after 0 in service? blocked -> 0x00

    // R10 + single form with fourth word
    wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h03); wr(1, 8'h00);
    set_irq(8'h00); set_irq(8'h40); wr(0, 8'h0E); rd(0);
    wr(0, 8'h0B); rd(0); wr(0, 8'h0A); rd(0);

    // single form, no fourth word: mask right after second word
    wr(0, 8'h12); wr(1, 8'hF8); wr(1, 8'h3C); rd(1);
    wr(0, 8'h11); wr(1, 8'h00); wr(1, 8'h80); wr(1, 8'h01);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: idle();
        1, 2: set_irq(cur_irq ^ 8'($urandom_range(0, 255) & $urandom_range(0, 255)));
        3: wr(1, ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : 8'h00);
        4: begin wr(0, 8'h0E); rd(0); end
        5: wr(0, 8'h20);
        6: wr(0, 8'h60 | 8'($urandom_range(0, 7)));
        7: wr(0, ($urandom_range(0, 1) == 1) ? 8'h0B : 8'h0A);
        8: rd($urandom_range(0, 1) == 1);
        default: wr(0, ($urandom_range(0, 1) == 1) ? 8'h40 : 8'hE5);
      endcase
    end
    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule